// File: doc/BRIEF.md
# Raster Timing Generator with Four Sync Channels

The block produces the timing of a progressive video raster from a pixel clock. A pixel counter steps across a programmable line length. A line counter steps through the lines of a field, and the field length is programmed as a count of half-lines. Four sync channels read that raster position. Each channel has its own horizontal pulse and its own vertical pulse. Each vertical edge is placed by a line number together with a pixel offset inside that line. Display interfaces with different pipeline latencies can therefore each receive syncs shifted by their own pixel delay, and a negative delay simply wraps back into the previous line.

Software programs the block through a single-cycle write port. A rectangle given by inclusive start and stop coordinates drives an active-video flag. Two field events set sticky interrupt status bits, and a mask gates them onto one interrupt line. The generator starts on a restart write. In master mode it runs at once. In slave mode it holds at the first pixel until an external sync input is seen. Writes made while the generator runs are staged and take effect at the next frame start, so no pulse is cut short in the middle of a frame.

Top module: `raster_timing_gen`

## Requirements
- R1: After reset the generator is halted at pixel 0 of line 1. All hsync, vsync, activeVid, irqStatus, irqMask and irq outputs are 0, and the position does not advance until a restart.
- R2: While running, curPix counts 0 up to lineLen-1, where lineLen is written at word address 1. curLine counts from 1 up to halfLines/2, where halfLines is written at address 2. Past the last pixel of the last line both counters return to pixel 0, line 1.
- R3: Each channel c has a horizontal word at address 16+4c, with the rise pixel in bits 15:0 and the fall pixel in bits 31:16. Its hsync is high from the rise pixel (inclusive) to the fall pixel (exclusive). It wraps past the line end when rise > fall, and it stays low when rise = fall.
- R4: Each channel has a vertical line word at address 17+4c (rise line in bits 15:0, fall line in bits 31:16) and a vertical offset word at address 18+4c (rise pixel in bits 15:0, fall pixel in bits 31:16). Its vsync is high from the rise point to the fall point, with the fall point excluded. It wraps across the frame end when the rise point comes later in the frame than the fall point, and it stays low when the two points are equal.
- R5: activeVid is high when the line lies within the start and stop lines and the pixel lies within the start and stop pixels, all bounds inclusive. The start word is at address 4 and the stop word at address 5, each with the line in bits 31:16 and the pixel in bits 15:0.
- R6: Writing a value with bit 0 set to address 3 places the position at pixel 0, line 1 on the next cycle and applies all staged settings immediately.
- R7: The mode word at address 0 selects the start behaviour at a restart. Bit 0 = 0 means master, which runs at once. Bit 0 = 1 means slave, which holds at pixel 0, line 1 until extSync is sampled high and then counts from the following cycle.
- R8: irqStatus bit 1 (top) is set on the cycle the position wraps to pixel 0, line 1. irqStatus bit 0 (bottom) is set on the cycle the position reaches pixel 0 of line (halfLines/2)/2 + 1.
- R9: Status bits stay set until a 1 is written to that bit at address 6. When an event and a clear of the same bit fall in the same cycle, the bit stays set.
- R10: Writing 1s to address 7 sets mask bits, and writing 1s to address 8 clears them. irq is high when any status bit and its mask bit are both set.
- R11: Line length, field length, window and channel words written while running take effect only at the next frame start.
- R12: The four channels are independent. Each compares only its own words against the shared position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| wrAddr | input | ADDR_W (6) | Register word address |
| wrData | input | 32 | Register write data |
| extSync | input | 1 | External start sync for slave mode |
| hsync | output | NUM_CH (4) | Horizontal sync, one bit per channel |
| vsync | output | NUM_CH (4) | Vertical sync, one bit per channel |
| activeVid | output | 1 | Active-video window flag |
| curPix | output | PIX_W (16) | Current pixel position |
| curLine | output | LINE_W (16) | Current line, counted from 1 |
| irqStatus | output | 2 | Sticky field events: bit 1 top, bit 0 bottom |
| irqMask | output | 2 | Interrupt mask |
| irq | output | 1 | Masked interrupt request |

## Verification
The hardest situation to reach from the ports is a status clear that lands on the exact edge where the top-field event fires. The bench tracks the cycle count since the last restart and issues the clear on the last pixel of the frame, so the write and the wrap share one edge. The bench also stages a new horizontal word in the middle of a frame. It then checks the old pulse in the rest of that frame and the new pulse in the next one. Every vertical pulse is compared over a full frame against a linear-position model, including one pulse that rises on the last line and falls in the next frame.

// File: rtl/vtg_pkg.sv
package vtg_pkg;

  localparam int unsigned ADR_MODE    = 0;
  localparam int unsigned ADR_LINELEN = 1;
  localparam int unsigned ADR_HALF    = 2;
  localparam int unsigned ADR_RESTART = 3;
  localparam int unsigned ADR_WSTART  = 4;
  localparam int unsigned ADR_WSTOP   = 5;
  localparam int unsigned ADR_STAT    = 6;
  localparam int unsigned ADR_MSET    = 7;
  localparam int unsigned ADR_MCLR    = 8;
  localparam int unsigned CH_BASE     = 16;
  localparam int unsigned CH_STRIDE   = 4;

  typedef enum logic [1:0] {
    ST_HALT = 2'd0,
    ST_WAIT = 2'd1,
    ST_RUN  = 2'd2
  } runState_t;

  typedef struct packed {
    logic restart;
    logic run;
    logic loadCfg;
  } vtgStrobes_t;

endpackage

// File: rtl/vtg_sync_chan.sv
module vtg_sync_chan #(
  parameter int ADDR_W = 6,
  parameter int PIX_W  = 16,
  parameter int LINE_W = 16,
  parameter int BASE   = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              loadCfg,
  input  logic [PIX_W-1:0]  curPix,
  input  logic [LINE_W-1:0] curLine,
  output logic              hsync,
  output logic              vsync
);

  localparam logic [ADDR_W-1:0] A_H  = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_VL = ADDR_W'(BASE + 1);
  localparam logic [ADDR_W-1:0] A_VO = ADDR_W'(BASE + 2);

  logic [31:0] stageH, stageVL, stageVO;
  logic [31:0] liveH, liveVL, liveVO;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageH  <= '0;
      stageVL <= '0;
      stageVO <= '0;
    end else if (wrEn) begin
      if (wrAddr == A_H)  stageH  <= wrData;
      if (wrAddr == A_VL) stageVL <= wrData;
      if (wrAddr == A_VO) stageVO <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      liveH  <= '0;
      liveVL <= '0;
      liveVO <= '0;
    end else if (loadCfg) begin
      liveH  <= stageH;
      liveVL <= stageVL;
      liveVO <= stageVO;
    end
  end

  logic [PIX_W-1:0]  hRise, hFall, vRisePix, vFallPix;
  logic [LINE_W-1:0] vRiseLine, vFallLine;

  assign hRise     = liveH[PIX_W-1:0];
  assign hFall     = liveH[16 +: PIX_W];
  assign vRiseLine = liveVL[LINE_W-1:0];
  assign vFallLine = liveVL[16 +: LINE_W];
  assign vRisePix  = liveVO[PIX_W-1:0];
  assign vFallPix  = liveVO[16 +: PIX_W];

  logic pastRise, pastFall, riseFirst, samePoint;

  always_comb begin
    pastRise  = (curLine > vRiseLine) || ((curLine == vRiseLine) && (curPix >= vRisePix));
    pastFall  = (curLine > vFallLine) || ((curLine == vFallLine) && (curPix >= vFallPix));
    riseFirst = (vRiseLine < vFallLine) || ((vRiseLine == vFallLine) && (vRisePix < vFallPix));
    samePoint = (vRiseLine == vFallLine) && (vRisePix == vFallPix);

    if (hRise == hFall)     hsync = 1'b0;
    else if (hRise < hFall) hsync = (curPix >= hRise) && (curPix < hFall);
    else                    hsync = (curPix >= hRise) || (curPix < hFall);

    if (samePoint)      vsync = 1'b0;
    else if (riseFirst) vsync = pastRise && !pastFall;
    else                vsync = pastRise || !pastFall;
  end

endmodule

// File: rtl/vtg_datapath.sv
module vtg_datapath
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PIX_W  = 16,
  parameter int LINE_W = 16,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  vtgStrobes_t       strb,
  output logic              evTop,
  output logic              evBot,
  output logic [NUM_CH-1:0] hsync,
  output logic [NUM_CH-1:0] vsync,
  output logic              activeVid,
  output logic [PIX_W-1:0]  curPix,
  output logic [LINE_W-1:0] curLine
);

  localparam logic [ADDR_W-1:0] A_LEN  = ADDR_W'(ADR_LINELEN);
  localparam logic [ADDR_W-1:0] A_HALF = ADDR_W'(ADR_HALF);
  localparam logic [ADDR_W-1:0] A_WST  = ADDR_W'(ADR_WSTART);
  localparam logic [ADDR_W-1:0] A_WSP  = ADDR_W'(ADR_WSTOP);

  logic [PIX_W-1:0] stageLen, liveLen;
  logic [LINE_W:0]  stageHalf, liveHalf;
  logic [31:0]      stageWinA, stageWinB, liveWinA, liveWinB;

  always_ff @(posedge clk) begin
    if (rst) begin
      stageLen  <= '0;
      stageHalf <= '0;
      stageWinA <= '0;
      stageWinB <= '0;
    end else if (wrEn) begin
      if (wrAddr == A_LEN)  stageLen  <= wrData[PIX_W-1:0];
      if (wrAddr == A_HALF) stageHalf <= wrData[LINE_W:0];
      if (wrAddr == A_WST)  stageWinA <= wrData;
      if (wrAddr == A_WSP)  stageWinB <= wrData;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      liveLen  <= '0;
      liveHalf <= '0;
      liveWinA <= '0;
      liveWinB <= '0;
    end else if (strb.loadCfg) begin
      liveLen  <= stageLen;
      liveHalf <= stageHalf;
      liveWinA <= stageWinA;
      liveWinB <= stageWinB;
    end
  end

  logic [LINE_W-1:0] linesPerField, midLine;
  logic lastPix, lastLine, atMid;

  assign linesPerField = liveHalf[LINE_W:1];
  assign midLine       = {1'b0, linesPerField[LINE_W-1:1]};
  assign lastPix       = (curPix == liveLen - PIX_W'(1));
  assign lastLine      = (curLine == linesPerField);
  assign atMid         = (curLine == midLine);
  assign evTop         = strb.run && lastPix && lastLine;
  assign evBot         = strb.run && lastPix && atMid && !lastLine;

  always_ff @(posedge clk) begin
    if (rst || strb.restart) begin
      curPix  <= '0;
      curLine <= LINE_W'(1);
    end else if (strb.run) begin
      if (lastPix) begin
        curPix  <= '0;
        curLine <= lastLine ? LINE_W'(1) : curLine + LINE_W'(1);
      end else begin
        curPix <= curPix + PIX_W'(1);
      end
    end
  end

  assign activeVid = (curLine >= liveWinA[16 +: LINE_W]) && (curLine <= liveWinB[16 +: LINE_W]) &&
                     (curPix  >= liveWinA[PIX_W-1:0])    && (curPix  <= liveWinB[PIX_W-1:0]);

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    vtg_sync_chan #(
      .ADDR_W(ADDR_W),
      .PIX_W (PIX_W),
      .LINE_W(LINE_W),
      .BASE  (CH_BASE + CH_STRIDE * g)
    ) i_chan (
      .clk    (clk),
      .rst    (rst),
      .wrEn   (wrEn),
      .wrAddr (wrAddr),
      .wrData (wrData),
      .loadCfg(strb.loadCfg),
      .curPix (curPix),
      .curLine(curLine),
      .hsync  (hsync[g]),
      .vsync  (vsync[g])
    );
  end

endmodule

// File: rtl/vtg_ctrl.sv
module vtg_ctrl
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [1:0]        wrBits,
  input  logic              extSync,
  input  logic              evTop,
  input  logic              evBot,
  output vtgStrobes_t       strb,
  output logic [1:0]        irqStatus,
  output logic [1:0]        irqMask,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(ADR_MODE);
  localparam logic [ADDR_W-1:0] A_RST  = ADDR_W'(ADR_RESTART);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(ADR_STAT);
  localparam logic [ADDR_W-1:0] A_MSET = ADDR_W'(ADR_MSET);
  localparam logic [ADDR_W-1:0] A_MCLR = ADDR_W'(ADR_MCLR);

  runState_t state;
  logic slaveMode, restartWr;
  logic [1:0] clrBits, setBits;

  assign restartWr = wrEn && (wrAddr == A_RST) && wrBits[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      slaveMode <= 1'b0;
      state     <= ST_HALT;
    end else begin
      if (wrEn && wrAddr == A_MODE) slaveMode <= wrBits[0];
      if (restartWr)                         state <= slaveMode ? ST_WAIT : ST_RUN;
      else if (state == ST_WAIT && extSync)  state <= ST_RUN;
    end
  end

  always_comb begin
    strb.restart = restartWr;
    strb.run     = (state == ST_RUN) && !restartWr;
    strb.loadCfg = restartWr || evTop;
  end

  assign setBits = {evTop, evBot};
  assign clrBits = (wrEn && wrAddr == A_STAT) ? wrBits : 2'b00;

  always_ff @(posedge clk) begin
    if (rst) begin
      irqStatus <= '0;
      irqMask   <= '0;
    end else begin
      irqStatus <= (irqStatus & ~clrBits) | setBits;
      if (wrEn && wrAddr == A_MSET)      irqMask <= irqMask | wrBits;
      else if (wrEn && wrAddr == A_MCLR) irqMask <= irqMask & ~wrBits;
    end
  end

  assign irq = |(irqStatus & irqMask);

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PIX_W  = 16,
  parameter int LINE_W = 16,
  parameter int NUM_CH = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [31:0]       wrData,
  input  logic              extSync,
  output logic [NUM_CH-1:0] hsync,
  output logic [NUM_CH-1:0] vsync,
  output logic              activeVid,
  output logic [PIX_W-1:0]  curPix,
  output logic [LINE_W-1:0] curLine,
  output logic [1:0]        irqStatus,
  output logic [1:0]        irqMask,
  output logic              irq
);

  vtgStrobes_t strb;
  logic evTop, evBot;

  vtg_ctrl #(.ADDR_W(ADDR_W)) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrBits   (wrData[1:0]),
    .extSync  (extSync),
    .evTop    (evTop),
    .evBot    (evBot),
    .strb     (strb),
    .irqStatus(irqStatus),
    .irqMask  (irqMask),
    .irq      (irq)
  );

  vtg_datapath #(
    .ADDR_W(ADDR_W),
    .PIX_W (PIX_W),
    .LINE_W(LINE_W),
    .NUM_CH(NUM_CH)
  ) i_dp (
    .clk      (clk),
    .rst      (rst),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .strb     (strb),
    .evTop    (evTop),
    .evBot    (evBot),
    .hsync    (hsync),
    .vsync    (vsync),
    .activeVid(activeVid),
    .curPix   (curPix),
    .curLine  (curLine)
  );

endmodule

// File: rtl/raster_timing_gen_chk.sv
module raster_timing_gen_chk
  import vtg_pkg::*;
#(
  parameter int ADDR_W = 6,
  parameter int PIX_W  = 16,
  parameter int LINE_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              wrEn,
  input logic [ADDR_W-1:0] wrAddr,
  input logic [1:0]        wrBits,
  input logic [PIX_W-1:0]  curPix,
  input logic [LINE_W-1:0] curLine,
  input logic [1:0]        irqStatus,
  input logic [1:0]        irqMask
);

  logic [1:0] clrNow;
  logic restartNow;

  assign clrNow     = (wrEn && wrAddr == ADDR_W'(ADR_STAT)) ? wrBits : 2'b00;
  assign restartNow = wrEn && (wrAddr == ADDR_W'(ADR_RESTART)) && wrBits[0];

  p_line_nonzero_r2: assert property (@(posedge clk) disable iff (rst)
    curLine != '0);

  p_top_event_r8: assert property (@(posedge clk) disable iff (rst)
    (curPix == '0 && curLine == LINE_W'(1) && $past(curLine) != LINE_W'(1) && !$past(restartNow))
      |-> irqStatus[1]);

  p_status_sticky_r9: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((($past(irqStatus) & ~$past(clrNow)) & ~irqStatus) == 2'b00));

  p_mask_set_r10: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == ADDR_W'(ADR_MSET)) |=> ((irqMask & $past(wrBits)) == $past(wrBits)));

  p_mask_clr_r10: assert property (@(posedge clk) disable iff (rst)
    (wrEn && wrAddr == ADDR_W'(ADR_MCLR)) |=> ((irqMask & $past(wrBits)) == 2'b00));

endmodule

bind raster_timing_gen raster_timing_gen_chk #(
  .ADDR_W(ADDR_W),
  .PIX_W (PIX_W),
  .LINE_W(LINE_W)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .wrEn     (wrEn),
  .wrAddr   (wrAddr),
  .wrBits   (wrData[1:0]),
  .curPix   (curPix),
  .curLine  (curLine),
  .irqStatus(irqStatus),
  .irqMask  (irqMask)
);

// File: tb/test_raster_timing_gen.sv
module test_raster_timing_gen;

  localparam int CLK_PERIOD = 10;
  localparam int LL = 20;           // pixels per line
  localparam int NL = 10;           // lines per field
  localparam int FR = LL * NL;      // cycles per frame

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wrEn = 1'b0;
  logic [5:0]  wrAddr = '0;
  logic [31:0] wrData = '0;
  logic        extSync = 1'b0;
  logic [3:0]  hsync, vsync;
  logic        activeVid;
  logic [15:0] curPix, curLine;
  logic [1:0]  irqStatus, irqMask;
  logic        irq;

  int checks = 0;
  int failures = 0;
  int k = 0;
  bit finished = 0;

  int hR[4], hF[4], vRL[4], vRO[4], vFL[4], vFO[4];

  always #(CLK_PERIOD / 2) clk = ~clk;

  raster_timing_gen i_raster_timing_gen (
    .clk(clk), .rst(rst), .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .extSync(extSync), .hsync(hsync), .vsync(vsync), .activeVid(activeVid),
    .curPix(curPix), .curLine(curLine), .irqStatus(irqStatus),
    .irqMask(irqMask), .irq(irq)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s k=%0d actual=%0h expected=%0h", req, k, act, exp);
    end
  endtask

  task automatic adv(input int n);
    repeat (n) begin
      @(negedge clk);
      k++;
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    wrEn = 1'b1; wrAddr = 6'(a); wrData = d;
    @(negedge clk);
    k++;
    wrEn = 1'b0; wrAddr = '0; wrData = '0;
  endtask

  task automatic goTo(input int phase);
    while ((k % FR) != phase) adv(1);
  endtask

  function automatic logic expH(input int r, input int f, input int x);
    if (r == f) return 1'b0;
    if (r < f) return (x >= r) && (x < f);
    return (x >= r) || (x < f);
  endfunction

  function automatic logic expV(input int c, input int p);
    int r, f;
    r = (vRL[c] - 1) * LL + vRO[c];
    f = (vFL[c] - 1) * LL + vFO[c];
    if (r == f) return 1'b0;
    if (r < f) return (p >= r) && (p < f);
    return (p >= r) || (p < f);
  endfunction

  task automatic setChan(input int c, input int a, input int b, input int rl, input int ro,
                         input int fl, input int fo);
    hR[c] = a; hF[c] = b; vRL[c] = rl; vRO[c] = ro; vFL[c] = fl; vFO[c] = fo;
    wr(16 + 4 * c, {16'(b), 16'(a)});
    wr(17 + 4 * c, {16'(fl), 16'(rl)});
    wr(18 + 4 * c, {16'(fo), 16'(ro)});
  endtask

  task automatic test_reset();
    check("R1 hsync", 32'(hsync), 0);
    check("R1 vsync", 32'(vsync), 0);
    check("R1 activeVid", 32'(activeVid), 0);
    check("R1 irq", 32'({irqStatus, irqMask, irq}), 0);
    adv(5);
    check("R1 halted pix", 32'(curPix), 0);
    check("R1 halted line", 32'(curLine), 1);
  endtask

  task automatic test_frame();
    logic [3:0] eh, ev;
    int px, ln, p;
    wr(1, LL);
    wr(2, 2 * NL);
    wr(4, {16'd3, 16'd4});
    wr(5, {16'd8, 16'd15});
    setChan(0, 2, 6, 1, 0, 3, 0);
    setChan(1, 17, 3, NL, 17, 2, 17);   // negative delay: rises on last line, wraps
    setChan(2, 5, 5, 4, 5, 4, 9);
    setChan(3, 0, 19, 7, 12, 5, 3);
    wr(3, 1);
    k = 0;
    for (int i = 0; i < FR; i++) begin
      px = k % LL; ln = 1 + (k / LL) % NL; p = (ln - 1) * LL + px;
      for (int c = 0; c < 4; c++) begin
        eh[c] = expH(hR[c], hF[c], px);
        ev[c] = expV(c, p);
      end
      check("R2 position", {curLine, curPix}, {16'(ln), 16'(px)});
      check("R3 R12 hsync", 32'(hsync), 32'(eh));
      check("R4 R12 vsync", 32'(vsync), 32'(ev));
      check("R5 activeVid", 32'(activeVid),
            32'((ln >= 3) && (ln <= 8) && (px >= 4) && (px <= 15)));
      if (k == FR / 2 - 1) check("R8 bottom before", 32'(irqStatus[0]), 0);
      if (k == FR / 2)     check("R8 bottom set", 32'(irqStatus[0]), 1);
      adv(1);
    end
    check("R2 wrap position", {curLine, curPix}, {16'd1, 16'd0});
    check("R8 top set", 32'(irqStatus), 3);
    check("R10 irq masked", 32'(irq), 0);
  endtask

  task automatic test_irq();
    wr(7, 2);
    check("R10 mask set", 32'(irqMask), 2);
    check("R10 irq high", 32'(irq), 1);
    wr(6, 2);
    check("R9 clear top", 32'(irqStatus), 1);
    check("R10 irq low", 32'(irq), 0);
    wr(8, 2);
    check("R10 mask clear", 32'(irqMask), 0);
    goTo(FR - 1);
    wr(6, 2);   // clear lands on the top-event edge
    check("R9 set wins", 32'(irqStatus[1]), 1);
    wr(6, 3);
    check("R9 cleared", 32'(irqStatus), 0);
  endtask

  task automatic test_staged();
    goTo(40);
    wr(16, {16'd12, 16'd8});
    goTo(63);
    check("R11 old pulse pix3", 32'(hsync[0]), 1);
    goTo(69);
    check("R11 old pulse pix9", 32'(hsync[0]), 0);
    goTo(3);
    check("R11 new pulse pix3", 32'(hsync[0]), 0);
    goTo(9);
    check("R11 new pulse pix9", 32'(hsync[0]), 1);
    hR[0] = 8; hF[0] = 12;
  endtask

  task automatic test_restart();
    wr(0, 1);
    adv(3);
    wr(3, 1);
    check("R6 restart position", {curLine, curPix}, {16'd1, 16'd0});
    adv(10);
    check("R7 slave holds", {curLine, curPix}, {16'd1, 16'd0});
    extSync = 1'b1;
    adv(1);
    extSync = 1'b0;
    check("R7 start cycle", 32'(curPix), 0);
    adv(9);
    check("R7 slave counts", 32'(curPix), 9);
    check("R6 config applied", 32'(hsync[0]), 1);
    wr(0, 0);
    adv(2);
    wr(3, 1);
    adv(7);
    check("R7 master runs", {curLine, curPix}, {16'd1, 16'd7});
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    test_reset();
    test_frame();
    test_irq();
    test_staged();
    test_restart();
    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule